// File: doc/BRIEF.md
# RGB LED Matrix Scan Driver

This block keeps a 32x32 RGB LED matrix lit without any help from software. The matrix is split into an upper and a lower half of 16 rows each. Two frame memories supply the pixels: one holds the upper half and one holds the lower half. The driver reads both memories with the same column in the same clock cycle. It serialises one bit-plane of a row pair onto six colour data lines and steps the panel's blank, latch and row-address lines. Brightness comes from binary coded modulation: bit-plane b of a row pair is shown for BASE_N·2^b clocks.

The next bit-plane is shifted into the panel while the current plane is on display. Row changes, latches and buffer swaps all happen with the panel blanked. A dimming input blanks the panel a fraction of each plane period early and leaves the period length unchanged. A buffer-select input picks one of two frames; the driver samples it only where one frame ends and the next begins. The frame memories are external and are assumed to have one clock of read latency. COLS and ROW_PAIRS must be powers of two.

Top module: `ledmx_refresh`

## Requirements
- R1: While reset is asserted, and on the first clock after it, pan_blank is 1, pan_latch is 0, pan_sclk is 0 and pan_row is 0.
- R2: After reset, the data for row pair 0, plane 0 is shifted in while pan_blank stays 1. pan_blank does not go low before the first latch pulse.
- R3: Every plane follows this order. pan_blank rises, then pan_row takes the new value, then pan_latch pulses high for exactly one clock while pan_blank is 1, then pan_blank is released. pan_latch is never high while pan_blank is 0.
- R4: pan_row changes only while pan_blank is 1 and was 1 in the previous clock. Row pairs advance 0,1,…,ROW_PAIRS-1 and then wrap. Each row pair receives planes 0 to BPC-1 in ascending order before the next row pair starts. Row value k lights rows k and k+ROW_PAIRS.
- R5: Exactly COLS rising edges of pan_sclk occur between two latch pulses. The data lines hold steady in the clock before each rising edge, and pan_sclk is 0 while pan_latch is high.
- R6: The data bit for plane p is taken from the 12-bit pixel as follows: red line bit 8+p, green line bit 4+p, blue line bit p. The bit shifted first lands on column 0, the leftmost column; the bit shifted last lands on column COLS-1.
- R7: The upper-half address is base + row·COLS + col. The lower-half address is base + (row+ROW_PAIRS)·COLS + col. Both are issued in the same cycle for the same column.
- R8: The time from one latch pulse to the next equals BASE_N·2^b + 3 clocks, where b is the plane that was latched first.
- R9: During plane b, pan_blank is low for P − floor(P·dim/2^DIM_W) clocks, where P = BASE_N·2^b and dim is the value sampled in the latch clock. The period itself does not change.
- R10: buf_sel = 0 selects base 0x000 and buf_sel = 1 selects base 2·ROW_PAIRS·COLS (0x400 by default). The value is sampled only when the shift of row pair 0, plane 0 begins, so a change in mid-frame is ignored until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_sel | input | 1 | Frame buffer to display from the next frame on |
| dim_level | input | DIM_W | Fraction of each plane period, in 1/2^DIM_W units, blanked early |
| top_addr | output | 2+log2(ROW_PAIRS)+log2(COLS) | Read address to the upper-half memory |
| bot_addr | output | 2+log2(ROW_PAIRS)+log2(COLS) | Read address to the lower-half memory |
| top_pix | input | 3·BPC | Upper-half pixel, one clock after top_addr |
| bot_pix | input | 3·BPC | Lower-half pixel, one clock after bot_addr |
| pan_r0 | output | 1 | Red serial data, upper half |
| pan_g0 | output | 1 | Green serial data, upper half |
| pan_b0 | output | 1 | Blue serial data, upper half |
| pan_r1 | output | 1 | Red serial data, lower half |
| pan_g1 | output | 1 | Green serial data, lower half |
| pan_b1 | output | 1 | Blue serial data, lower half |
| pan_sclk | output | 1 | Shift clock shared by all six lines |
| pan_latch | output | 1 | Transfers shifted data to the column outputs |
| pan_blank | output | 1 | High turns all LEDs off |
| pan_row | output | log2(ROW_PAIRS) | Row-pair address |

## Verification
The bench models the panel's six shift registers and compares every latched row against pixels computed from the address arithmetic. A design that reversed the column order, picked the wrong colour field or bit, or swapped the two halves would latch a mismatching vector. Latch-to-latch spacing and blank-low time are measured for each plane under several dimming values. A wrong doubling would show up as a shortened period, and a dimming scheme that stretched or cut the wait would show up as a blank-low count that disagrees with the floor formula. The buffer input is flipped in the middle of a frame, so a design that switches buffers at once would latch data from the wrong frame for the rest of that frame.

// File: rtl/ledmx_pkg.sv
// Shared types for the LED matrix refresh driver.
package ledmx_pkg;

    // Steps of the per-plane refresh sequence.
    typedef enum logic [2:0] {
        SEQ_PRIME,   // initial shift with the panel dark
        SEQ_BLANK,   // blank the panel
        SEQ_ADDR,    // move the row address under blank
        SEQ_LATCH,   // transfer shifted data, start next shift
        SEQ_SHOW     // panel lit for the plane period
    } seq_state_t;

    // One bit per colour line of a half panel.
    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_bits_t;

endpackage

// File: rtl/ledmx_col_shifter.sv
// Column shifter: walks the columns once per start pulse, issues the column
// index, picks one plane bit per colour from both half-panel pixels and
// produces the serial shift clock.
// Assumes: the pixel arrives one clock after the column index; plane is held
// constant during a shift; SCLK_HALF >= 1.
module ledmx_col_shifter
    import ledmx_pkg::*;
#(
    parameter int COLS      = 32,
    parameter int SCLK_HALF = 2,
    parameter int BPC       = 4,
    localparam int COL_W    = $clog2(COLS),
    localparam int PL_W     = $clog2(BPC),
    localparam int PIX_W    = 3 * BPC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PL_W-1:0]  plane,
    input  logic [PIX_W-1:0] pix [2],
    output logic [COL_W-1:0] col,
    output logic             busy,
    output logic             sclk,
    output rgb_bits_t        rgb [2]
);
    // Per column: fetch, wait, SCLK_HALF low cycles, SCLK_HALF high cycles.
    localparam int COL_CYC = 2 * SCLK_HALF + 2;
    localparam int PH_W    = $clog2(COL_CYC);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(COL_CYC - 1);
    localparam logic [PH_W-1:0]  PH_LOAD  = PH_W'(1);
    localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(SCLK_HALF + 2);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    logic [PH_W-1:0]  ph_q;
    logic [COL_W-1:0] col_q;
    logic             busy_q;

    // Column and phase stepping across one row shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            col_q  <= '0;
            ph_q   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                col_q  <= '0;
                ph_q   <= '0;
            end
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
            if (col_q == COL_LAST) busy_q <= 1'b0;
            else                   col_q  <= col_q + 1'b1;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // One data register triple per half panel.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [BPC-1:0] red_f, grn_f, blu_f;
        rgb_bits_t      bits_q;

        assign red_f = pix[h][3*BPC-1:2*BPC];
        assign grn_f = pix[h][2*BPC-1:BPC];
        assign blu_f = pix[h][BPC-1:0];

        // Capture the selected plane bit once the pixel has arrived.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else if (busy_q && ph_q == PH_LOAD) begin
                bits_q.r <= red_f[plane];
                bits_q.g <= grn_f[plane];
                bits_q.b <= blu_f[plane];
            end
        end

        assign rgb[h] = bits_q;
    end

    assign col  = col_q;
    assign busy = busy_q;
    assign sclk = busy_q && (ph_q >= PH_RISE);

endmodule

// File: rtl/ledmx_plane_timer.sv
// Plane timer: on load, computes the period BASE_N << plane and the lit span
// left after early blanking, then counts clocks while run is high.
// Assumes: load and run are never high together.
module ledmx_plane_timer #(
    parameter int BASE_N = 256,
    parameter int BPC    = 4,
    parameter int DIM_W  = 4,
    localparam int PL_W  = $clog2(BPC),
    localparam int MAX_P = BASE_N * (2 ** (BPC - 1)),
    localparam int CNT_W = $clog2(MAX_P + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [PL_W-1:0]  plane,
    input  logic [DIM_W-1:0] dim,
    output logic             done,
    output logic             lit
);
    localparam int PROD_W = CNT_W + DIM_W;

    logic [CNT_W-1:0]  cnt_q, per_q, on_q;
    logic [CNT_W-1:0]  per_new, cut;
    logic [PROD_W-1:0] prod;

    // Period for the plane being loaded and the share blanked early.
    always_comb begin
        per_new = CNT_W'(BASE_N) << plane;
        prod    = PROD_W'(per_new) * PROD_W'(dim);
        cut     = CNT_W'(prod >> DIM_W);
    end

    // Elapsed-time counter with per-plane limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= CNT_W'(BASE_N);
            on_q  <= '0;
        end else if (load) begin
            cnt_q <= '0;
            per_q <= per_new;
            on_q  <= per_new - cut;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == per_q - 1'b1);
    assign lit  = (cnt_q < on_q);

endmodule

// File: rtl/ledmx_sequencer.sv
// Refresh sequencer: primes the first plane, then for every plane blanks the
// panel, moves the row address, latches, starts the next shift and shows the
// plane for its period. Tracks which row pair, plane and buffer is shifted.
// Assumes: a shift always finishes within one base period.
module ledmx_sequencer
    import ledmx_pkg::*;
#(
    parameter int ROW_PAIRS = 16,
    parameter int BPC       = 4,
    localparam int RW       = $clog2(ROW_PAIRS),
    localparam int PL_W     = $clog2(BPC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            buf_sel,
    input  logic            shift_busy,
    input  logic            plane_done,
    input  logic            plane_lit,
    output logic            shift_start,
    output logic            tmr_load,
    output logic            tmr_run,
    output logic [RW-1:0]   sh_row,
    output logic [PL_W-1:0] sh_plane,
    output logic            sh_buf,
    output logic [RW-1:0]   pan_row,
    output logic            pan_latch,
    output logic            pan_blank
);
    localparam logic [RW-1:0]   ROW_LAST   = RW'(ROW_PAIRS - 1);
    localparam logic [PL_W-1:0] PLANE_LAST = PL_W'(BPC - 1);

    seq_state_t      state_q;
    logic            kick_q;
    logic [RW-1:0]   row_q;
    logic [RW-1:0]   srow_q;
    logic [PL_W-1:0] splane_q;
    logic            sbuf_q;

    // State progression and shifted-plane bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_PRIME;
            kick_q   <= 1'b0;
            row_q    <= '0;
            srow_q   <= '0;
            splane_q <= '0;
            sbuf_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_PRIME: begin
                    if (!kick_q) begin
                        kick_q <= 1'b1;
                        sbuf_q <= buf_sel;
                    end else if (!shift_busy) begin
                        state_q <= SEQ_BLANK;
                    end
                end
                SEQ_BLANK: state_q <= SEQ_ADDR;
                SEQ_ADDR: begin
                    row_q   <= srow_q;
                    state_q <= SEQ_LATCH;
                end
                SEQ_LATCH: begin
                    state_q <= SEQ_SHOW;
                    if (splane_q == PLANE_LAST) begin
                        splane_q <= '0;
                        if (srow_q == ROW_LAST) begin
                            srow_q <= '0;
                            sbuf_q <= buf_sel;
                        end else begin
                            srow_q <= srow_q + 1'b1;
                        end
                    end else begin
                        splane_q <= splane_q + 1'b1;
                    end
                end
                SEQ_SHOW: begin
                    if (plane_done && !shift_busy) state_q <= SEQ_BLANK;
                end
                default: state_q <= SEQ_BLANK;
            endcase
        end
    end

    assign shift_start = (state_q == SEQ_PRIME && !kick_q) || (state_q == SEQ_LATCH);
    assign tmr_load    = (state_q == SEQ_LATCH);
    assign tmr_run     = (state_q == SEQ_SHOW);
    assign sh_row      = srow_q;
    assign sh_plane    = splane_q;
    assign sh_buf      = sbuf_q;
    assign pan_row     = row_q;
    assign pan_latch   = (state_q == SEQ_LATCH);
    assign pan_blank   = !((state_q == SEQ_SHOW) && plane_lit);

endmodule

// File: rtl/ledmx_refresh.sv
// LED matrix refresh driver top: joins the sequencer, column shifter and
// plane timer, forms the two half-panel memory addresses and drives the pins.
// Assumes: COLS and ROW_PAIRS are powers of two, BPC >= 2,
// BASE_N > COLS * (2*SCLK_HALF + 2), memories have one clock of read latency.
module ledmx_refresh
    import ledmx_pkg::*;
#(
    parameter int COLS      = 32,
    parameter int ROW_PAIRS = 16,
    parameter int BPC       = 4,
    parameter int SCLK_HALF = 2,
    parameter int BASE_N    = 256,
    parameter int DIM_W     = 4,
    localparam int COL_W    = $clog2(COLS),
    localparam int RW       = $clog2(ROW_PAIRS),
    localparam int AW       = 2 + RW + COL_W,
    localparam int PIX_W    = 3 * BPC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_sel,
    input  logic [DIM_W-1:0] dim_level,
    output logic [AW-1:0]    top_addr,
    output logic [AW-1:0]    bot_addr,
    input  logic [PIX_W-1:0] top_pix,
    input  logic [PIX_W-1:0] bot_pix,
    output logic             pan_r0,
    output logic             pan_g0,
    output logic             pan_b0,
    output logic             pan_r1,
    output logic             pan_g1,
    output logic             pan_b1,
    output logic             pan_sclk,
    output logic             pan_latch,
    output logic             pan_blank,
    output logic [RW-1:0]    pan_row
);
    localparam int PL_W = $clog2(BPC);

    logic             shift_start, shift_busy;
    logic             tmr_load, tmr_run, plane_done, plane_lit;
    logic [RW-1:0]    sh_row;
    logic [PL_W-1:0]  sh_plane;
    logic             sh_buf;
    logic [COL_W-1:0] col;
    logic [PIX_W-1:0] pix_pair [2];
    rgb_bits_t        rgb_pair [2];

    ledmx_sequencer #(
        .ROW_PAIRS (ROW_PAIRS),
        .BPC       (BPC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_sel     (buf_sel),
        .shift_busy  (shift_busy),
        .plane_done  (plane_done),
        .plane_lit   (plane_lit),
        .shift_start (shift_start),
        .tmr_load    (tmr_load),
        .tmr_run     (tmr_run),
        .sh_row      (sh_row),
        .sh_plane    (sh_plane),
        .sh_buf      (sh_buf),
        .pan_row     (pan_row),
        .pan_latch   (pan_latch),
        .pan_blank   (pan_blank)
    );

    assign pix_pair[0] = top_pix;
    assign pix_pair[1] = bot_pix;

    ledmx_col_shifter #(
        .COLS      (COLS),
        .SCLK_HALF (SCLK_HALF),
        .BPC       (BPC)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (shift_start),
        .plane (sh_plane),
        .pix   (pix_pair),
        .col   (col),
        .busy  (shift_busy),
        .sclk  (pan_sclk),
        .rgb   (rgb_pair)
    );

    ledmx_plane_timer #(
        .BASE_N (BASE_N),
        .BPC    (BPC),
        .DIM_W  (DIM_W)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (tmr_run),
        .plane (sh_plane),
        .dim   (dim_level),
        .done  (plane_done),
        .lit   (plane_lit)
    );

    // Frame base, half select, row pair and column form each address.
    assign top_addr = {sh_buf, 1'b0, sh_row, col};
    assign bot_addr = {sh_buf, 1'b1, sh_row, col};

    assign pan_r0 = rgb_pair[0].r;
    assign pan_g0 = rgb_pair[0].g;
    assign pan_b0 = rgb_pair[0].b;
    assign pan_r1 = rgb_pair[1].r;
    assign pan_g1 = rgb_pair[1].g;
    assign pan_b1 = rgb_pair[1].b;

endmodule

// File: rtl/ledmx_checks.sv
// Protocol checks on the panel pins of the refresh driver; bound to the top.
module ledmx_checks #(
    parameter int RW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pan_blank,
    input logic          pan_latch,
    input logic          pan_sclk,
    input logic [RW-1:0] pan_row,
    input logic [5:0]    pan_lines
);
    assert_latch_blanked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pan_latch |-> pan_blank);

    assert_latch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pan_latch |=> !pan_latch);

    assert_row_under_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pan_row) |-> (pan_blank && $past(pan_blank)));

    assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pan_sclk) |-> $stable(pan_lines));

    assert_sclk_quiet_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pan_latch |-> !pan_sclk);
endmodule

bind ledmx_refresh ledmx_checks #(.RW(RW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .pan_blank (pan_blank),
    .pan_latch (pan_latch),
    .pan_sclk  (pan_sclk),
    .pan_row   (pan_row),
    .pan_lines ({pan_b1, pan_g1, pan_r1, pan_b0, pan_g0, pan_r0})
);

// File: tb/sim_ledmx_refresh.sv
module sim_ledmx_refresh;
    localparam int COLS = 8;
    localparam int RP   = 4;
    localparam int BPC  = 4;
    localparam int SH   = 2;
    localparam int N    = 52;
    localparam int DW   = 4;
    localparam int CW   = $clog2(COLS);
    localparam int RW   = $clog2(RP);
    localparam int AW   = 2 + RW + CW;
    localparam int PW   = 3 * BPC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_sel = 1'b0;
    logic [DW-1:0] dim_level = '0;
    logic [AW-1:0] top_addr, bot_addr;
    logic [PW-1:0] top_pix = '0, bot_pix = '0;
    logic pan_r0, pan_g0, pan_b0, pan_r1, pan_g1, pan_b1;
    logic pan_sclk, pan_latch, pan_blank;
    logic [RW-1:0] pan_row;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ledmx_refresh #(.COLS(COLS), .ROW_PAIRS(RP), .BPC(BPC), .SCLK_HALF(SH),
                    .BASE_N(N), .DIM_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .buf_sel(buf_sel), .dim_level(dim_level),
        .top_addr(top_addr), .bot_addr(bot_addr), .top_pix(top_pix), .bot_pix(bot_pix),
        .pan_r0(pan_r0), .pan_g0(pan_g0), .pan_b0(pan_b0),
        .pan_r1(pan_r1), .pan_g1(pan_g1), .pan_b1(pan_b1),
        .pan_sclk(pan_sclk), .pan_latch(pan_latch), .pan_blank(pan_blank),
        .pan_row(pan_row));

    function automatic logic [PW-1:0] pix_fn(input int a);
        logic [31:0] x;
        x = 32'(a) * 32'd40503 + 32'd977;
        return x[16:5];
    endfunction

    function automatic int frame_addr(input int b, input int h, input int r, input int c);
        return b * (2 * RP * COLS) + (h * RP + r) * COLS + c;
    endfunction

    // Synchronous-read memory model for both halves.
    always @(posedge clk) begin
        top_pix <= pix_fn(int'(top_addr));
        bot_pix <= pix_fn(int'(bot_addr));
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Panel model and protocol monitor, sampled on the falling edge.
    logic [5:0]      lin;
    logic [COLS-1:0] sr [6];
    logic            prev_sclk, prev_latch;
    logic [RW-1:0]   prev_row;
    int pulses, cyc_cnt, low_cnt, lat_count;
    int exp_row, exp_plane, exp_buf, prev_plane, prev_dim;
    bit first;

    assign lin = {pan_b1, pan_g1, pan_r1, pan_b0, pan_g0, pan_r0};

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sclk = 1'b0; prev_latch = 1'b0; prev_row = '0;
            pulses = 0; cyc_cnt = 0; low_cnt = 0; lat_count = 0;
            exp_row = 0; exp_plane = 0; exp_buf = int'(buf_sel);
            prev_plane = 0; prev_dim = 0; first = 1'b1;
            for (int i = 0; i < 6; i++) sr[i] = '0;
        end else begin
            cyc_cnt++;
            if (!pan_blank) low_cnt++;
            if (pan_row != prev_row)
                chk(pan_blank, "R4 row address moved while lit", pan_blank, 1);
            if (pan_sclk && !prev_sclk) begin
                for (int i = 0; i < 6; i++) sr[i] = {lin[i], sr[i][COLS-1:1]};
                pulses++;
            end
            if (pan_latch && !prev_latch) begin
                chk(pan_blank, "R3 latch pulse with blank high", pan_blank, 1);
                chk(pulses == COLS, "R5 shift pulses per row", pulses, COLS);
                chk(int'(pan_row) == exp_row, "R4 row pair order", pan_row, exp_row);
                for (int h = 0; h < 2; h++) begin
                    for (int k = 0; k < 3; k++) begin
                        logic [COLS-1:0] ev;
                        logic [PW-1:0]   px;
                        for (int c = 0; c < COLS; c++) begin
                            px = pix_fn(frame_addr(exp_buf, h, exp_row, c));
                            ev[c] = px[(2 - k) * BPC + exp_plane];
                        end
                        chk(sr[h*3+k] == ev, "R6 R7 R10 latched plane data",
                            longint'(sr[h*3+k]), longint'(ev));
                    end
                end
                if (first) begin
                    chk(low_cnt == 0, "R2 blank held through priming", low_cnt, 0);
                end else begin
                    int per;
                    per = N << prev_plane;
                    chk(cyc_cnt == per + 3, "R8 plane period", cyc_cnt, per + 3);
                    chk(low_cnt == per - ((per * prev_dim) >> DW), "R9 lit span under dimming",
                        low_cnt, per - ((per * prev_dim) >> DW));
                end
                first = 1'b0;
                prev_plane = exp_plane;
                prev_dim = int'(dim_level);
                cyc_cnt = 0; low_cnt = 0; pulses = 0;
                lat_count++;
                if (exp_plane == BPC - 1) begin
                    exp_plane = 0;
                    if (exp_row == RP - 1) begin
                        exp_row = 0;
                        exp_buf = int'(buf_sel);
                    end else begin
                        exp_row++;
                    end
                end else begin
                    exp_plane++;
                end
            end
            prev_sclk = pan_sclk;
            prev_latch = pan_latch;
            prev_row = pan_row;
        end
    end

    task automatic at_latch(input int n);
        wait (lat_count >= n);
        @(posedge clk); #1;
    endtask

    // Stimulus: reset checks, then buffer flips and a dimming sweep.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pan_blank == 1'b1, "R1 blank in reset", pan_blank, 1);
        chk(pan_latch == 1'b0, "R1 latch in reset", pan_latch, 0);
        chk(pan_sclk == 1'b0, "R1 sclk in reset", pan_sclk, 0);
        chk(pan_row == '0, "R1 row in reset", pan_row, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(pan_blank == 1'b1 && pan_latch == 1'b0 && pan_sclk == 1'b0,
            "R1 pins just after reset", {pan_blank, pan_latch, pan_sclk}, 3'b100);
        at_latch(6);   buf_sel = 1'b1;       // mid-frame: must wait for frame 1 (R10)
        at_latch(20);  dim_level = DW'(4);
        at_latch(30);  dim_level = DW'(8);
        at_latch(40);  buf_sel = 1'b0;
        at_latch(50);  dim_level = DW'(15);
        at_latch(70);  dim_level = DW'(1);
        at_latch(100);
        report();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired after %0d latches", lat_count);
        report();
    end
endmodule